// File: doc/BRIEF.md
# Boot ROM overlay address decoder

This block turns a 32-bit physical read address into byte reads from three memories. The memories are main RAM at the bottom of the address space, a flash device mirrored across a 16 MiB window at the top, and a 512-byte boot ROM. While the overlay is active, the boot ROM covers the last 512 bytes of that window. An optional alias region mirrors main RAM. A read is one byte, a 16-bit halfword or a 32-bit word. Each byte of a wider read is decoded on its own at consecutive addresses, and the bytes are packed little-endian.

A build parameter selects the retail variant or the development variant. The retail variant has 64 MiB of RAM and a boot ROM whose overlay is enabled by reset. The development variant has 128 MiB of RAM and no boot ROM. In the retail variant, software hides the boot ROM with a one-cycle disable command. Only a reset brings the overlay back. The memories are behavioural stubs whose contents are fixed functions of the offset, so a read shows which region served each byte.

Top module: `boot_overlay_decoder`

## Requirements
- R1: A byte address below the RAM size (0x04000000 retail, 0x08000000 development) is served by RAM at offset o = address. Its value is o[7:0] XOR o[26:19].
- R2: A byte address at or above 0xFF000000 that is not claimed by the overlay is served by flash at offset f = (address − 0xFF000000) mod 0x40000. Its value is f[7:0] XOR f[17:10] XOR 0x3C.
- R3: While the overlay is active, a byte address at or above 0xFFFFFE00 is served by the boot ROM at offset b = address − 0xFFFFFE00, taking priority over flash. Its value is (NOT b[7:0]) XOR (b[8] << 7).
- R4: A high cycle on `ovl_disable` clears the overlay from the next cycle on, and `ovl_active` then stays low until reset. After that the top 512 bytes read from the flash mirror.
- R5: After reset `ovl_active` is 1 in the retail variant. It is 0 at all times in the development variant, which never serves boot ROM bytes.
- R6: A byte address that maps to no region reads as 0x00, and `rd_err` is set for the read. `rd_err` is 0 when every active byte was mapped.
- R7: `rd_size` code 0 reads 1 byte, code 1 reads 2 bytes, and codes 2 and 3 read 4 bytes. Byte k comes from address+k and sits in `rd_data[8k+7:8k]`. Lanes beyond the size are zero.
- R8: With the alias enabled, an address in [0xF0000000, 0xF0000000 + RAM size) reads RAM at offset address − 0xF0000000. With the alias disabled, that range is unmapped.
- R9: Every byte of a read is decoded separately. A read that crosses a region boundary mixes regions. A read that runs past 0xFFFFFFFF continues at address 0 in RAM.
- R10: `rd_valid` is high in exactly the cycle after a cycle with `rd_req` high, with `rd_data` and `rd_err` for that request. After reset `rd_valid`, `rd_data` and `rd_err` are 0.
- R11: A read issued in the same cycle as `ovl_disable` is decoded with the overlay state from before the disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request for this cycle |
| rd_addr | input | 32 | Byte address of the first byte |
| rd_size | input | 2 | Access size code (0 byte, 1 halfword, 2 or 3 word) |
| ovl_disable | input | 1 | Command that hides the boot ROM overlay until reset |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Little-endian read data |
| rd_err | output | 1 | At least one byte of the read was unmapped |
| ovl_active | output | 1 | Boot ROM overlay currently enabled |

## Verification
The bench builds two copies side by side and drives the same reads into both. One is the retail variant with the RAM alias decoded. The other is the development variant with the alias left undecoded. This pairing makes the same address show different behaviour in each copy:
- the 64 MiB and 128 MiB RAM limits,
- the boot ROM against flash at the top 512 bytes,
- the alias as a RAM mirror against an unmapped range.

Directed tests on the retail copy cover the sticky disable, a disable that lands together with a read, and the return of the overlay after reset.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

   typedef enum logic [1:0] {
      RG_NONE  = 2'd0,
      RG_RAM   = 2'd1,
      RG_FLASH = 2'd2,
      RG_BOOT  = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } size_e;

   // stub contents: fixed functions of the region offset
   function automatic logic [7:0] ram_stub_byte(input logic [31:0] off);
      return off[7:0] ^ off[26:19];
   endfunction

   function automatic logic [7:0] flash_stub_byte(input logic [31:0] off);
      return off[7:0] ^ off[17:10] ^ 8'h3C;
   endfunction

   function automatic logic [7:0] boot_stub_byte(input logic [31:0] off);
      return (~off[7:0]) ^ {off[8], 7'b0};
   endfunction

   function automatic logic is_pow2(input logic [31:0] v);
      return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
   endfunction

endpackage

// File: rtl/bovl_lane_decode.sv
module bovl_lane_decode
   import boot_ovl_pkg::*;
#(
   parameter logic [31:0] RAM_BYTES       = 32'h0400_0000,
   parameter logic [31:0] FLASH_WIN_BYTES = 32'h0100_0000,
   parameter logic [31:0] FLASH_DEV_BYTES = 32'h0004_0000,
   parameter logic [31:0] BOOT_BYTES      = 32'h0000_0200,
   parameter bit          BOOT_PRESENT    = 1'b1,
   parameter bit          ALIAS_EN        = 1'b1,
   parameter logic [31:0] ALIAS_BASE      = 32'hF000_0000
) (
   input  logic [31:0] lane_addr,
   input  logic        ovl_on,
   output region_e     lane_region,
   output logic [31:0] lane_off
);

   localparam logic [31:0] FLASH_BASE = 32'h0 - FLASH_WIN_BYTES;
   localparam logic [31:0] BOOT_BASE  = 32'h0 - BOOT_BYTES;
   localparam logic [31:0] FLASH_MASK = FLASH_DEV_BYTES - 32'd1;

   logic        hit_ram;
   logic        hit_boot;
   logic        hit_flash;
   logic        hit_alias;
   logic [31:0] alias_off;

   assign hit_ram   = lane_addr < RAM_BYTES;
   assign hit_flash = lane_addr >= FLASH_BASE;
   assign alias_off = lane_addr - ALIAS_BASE;

   generate
      if (BOOT_PRESENT) begin : g_boot
         assign hit_boot = ovl_on && (lane_addr >= BOOT_BASE);
      end else begin : g_no_boot
         assign hit_boot = 1'b0;
      end

      if (ALIAS_EN) begin : g_alias
         assign hit_alias = (lane_addr >= ALIAS_BASE) && (alias_off < RAM_BYTES);
      end else begin : g_no_alias
         assign hit_alias = 1'b0;
      end
   endgenerate

   // priority: RAM, boot overlay, flash window, RAM alias
   always_comb begin
      lane_region = RG_NONE;
      lane_off    = 32'd0;
      if (hit_ram) begin
         lane_region = RG_RAM;
         lane_off    = lane_addr;
      end else if (hit_boot) begin
         lane_region = RG_BOOT;
         lane_off    = lane_addr - BOOT_BASE;
      end else if (hit_flash) begin
         lane_region = RG_FLASH;
         lane_off    = (lane_addr - FLASH_BASE) & FLASH_MASK;
      end else if (hit_alias) begin
         lane_region = RG_RAM;
         lane_off    = alias_off;
      end
   end

endmodule

// File: rtl/bovl_stub_mem.sv
module bovl_stub_mem
   import boot_ovl_pkg::*;
#(
   parameter bit BOOT_PRESENT = 1'b1
) (
   input  region_e     lane_region,
   input  logic [31:0] lane_off,
   output logic [7:0]  lane_byte
);

   logic [7:0] ram_b;
   logic [7:0] flash_b;
   logic [7:0] boot_b;

   assign ram_b   = ram_stub_byte(lane_off);
   assign flash_b = flash_stub_byte(lane_off);

   generate
      if (BOOT_PRESENT) begin : g_boot_rom
         assign boot_b = boot_stub_byte(lane_off);
      end else begin : g_no_boot_rom
         assign boot_b = 8'h00;
      end
   endgenerate

   always_comb begin
      unique case (lane_region)
         RG_RAM:   lane_byte = ram_b;
         RG_FLASH: lane_byte = flash_b;
         RG_BOOT:  lane_byte = boot_b;
         default:  lane_byte = 8'h00;
      endcase
   end

endmodule

// File: rtl/bovl_overlay_latch.sv
module bovl_overlay_latch #(
   parameter bit BOOT_PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dis_cmd,
   output logic active
);

   generate
      if (BOOT_PRESENT) begin : g_latch
         logic act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               act_q <= 1'b1;
            else if (dis_cmd)
               act_q <= 1'b0;
         end
         assign active = act_q;
      end else begin : g_tied_off
         logic unused_cmd;
         assign unused_cmd = clk ^ rst_n ^ dis_cmd;
         assign active     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
   import boot_ovl_pkg::*;
#(
   parameter bit          DEV_BUILD        = 1'b0,
   parameter bit          ALIAS_EN         = 1'b1,
   parameter logic [31:0] RETAIL_RAM_BYTES = 32'h0400_0000,
   parameter logic [31:0] DEV_RAM_BYTES    = 32'h0800_0000,
   parameter logic [31:0] FLASH_WIN_BYTES  = 32'h0100_0000,
   parameter logic [31:0] FLASH_DEV_BYTES  = 32'h0004_0000,
   parameter logic [31:0] BOOT_BYTES       = 32'h0000_0200,
   parameter logic [31:0] ALIAS_BASE       = 32'hF000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_req,
   input  logic [31:0] rd_addr,
   input  logic [1:0]  rd_size,
   input  logic        ovl_disable,
   output logic        rd_valid,
   output logic [31:0] rd_data,
   output logic        rd_err,
   output logic        ovl_active
);

   localparam int          LANES        = 4;
   localparam bit          BOOT_PRESENT = !DEV_BUILD;
   localparam logic [31:0] RAM_BYTES    = DEV_BUILD ? DEV_RAM_BYTES : RETAIL_RAM_BYTES;

   // elaboration-time parameter checks
   generate
      if (!is_pow2(FLASH_DEV_BYTES) || !is_pow2(FLASH_WIN_BYTES) ||
          !is_pow2(BOOT_BYTES) || !is_pow2(RAM_BYTES)) begin : g_bad_pow2
         initial $fatal(1, "region sizes must be powers of two");
      end
      if (BOOT_BYTES > FLASH_WIN_BYTES) begin : g_bad_boot
         initial $fatal(1, "boot overlay larger than flash window");
      end
      if (FLASH_DEV_BYTES > FLASH_WIN_BYTES) begin : g_bad_flash
         initial $fatal(1, "flash device larger than its window");
      end
   endgenerate

   logic [LANES-1:0]      lane_on;
   logic [LANES-1:0]      lane_err;
   logic [LANES-1:0][7:0] lane_byte;
   logic                  ovl_on;

   bovl_overlay_latch #(
      .BOOT_PRESENT(BOOT_PRESENT)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .dis_cmd(ovl_disable),
      .active (ovl_on)
   );

   assign ovl_active = ovl_on;

   always_comb begin
      unique case (size_e'(rd_size))
         SZ_BYTE: lane_on = 4'b0001;
         SZ_HALF: lane_on = 4'b0011;
         default: lane_on = 4'b1111;
      endcase
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [31:0] la;
         region_e     rg;
         logic [31:0] off;
         logic [7:0]  b;

         assign la = rd_addr + 32'(k);

         bovl_lane_decode #(
            .RAM_BYTES      (RAM_BYTES),
            .FLASH_WIN_BYTES(FLASH_WIN_BYTES),
            .FLASH_DEV_BYTES(FLASH_DEV_BYTES),
            .BOOT_BYTES     (BOOT_BYTES),
            .BOOT_PRESENT   (BOOT_PRESENT),
            .ALIAS_EN       (ALIAS_EN),
            .ALIAS_BASE     (ALIAS_BASE)
         ) u_dec (
            .lane_addr  (la),
            .ovl_on     (ovl_on),
            .lane_region(rg),
            .lane_off   (off)
         );

         bovl_stub_mem #(
            .BOOT_PRESENT(BOOT_PRESENT)
         ) u_mem (
            .lane_region(rg),
            .lane_off   (off),
            .lane_byte  (b)
         );

         assign lane_byte[k] = lane_on[k] ? b : 8'h00;
         assign lane_err[k]  = lane_on[k] && (rg == RG_NONE);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 32'd0;
         rd_err   <= 1'b0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_data <= lane_byte;
            rd_err  <= |lane_err;
         end
      end
   end

endmodule

// File: rtl/bovl_checker.sv
module bovl_checker #(
   parameter bit DEV_BUILD = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_req,
   input logic [1:0]  rd_size,
   input logic        ovl_disable,
   input logic        rd_valid,
   input logic [31:0] rd_data,
   input logic        ovl_active
);

   // R4: once cleared, the overlay stays off
   a_r4_sticky_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_active |=> !ovl_active);

   // R4: the overlay only drops after a disable command
   a_r4_clear_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovl_active) |-> $past(ovl_disable));

   // R10: valid follows a request by one cycle
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

   // R7: inactive lanes are zero
   a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_size == 2'd0) |=> (rd_data[31:8] == 24'd0));

   a_r7_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_size == 2'd1) |=> (rd_data[31:16] == 16'd0));

   generate
      if (DEV_BUILD) begin : g_dev
         // R5: no overlay in the development variant
         a_r5_dev_no_overlay: assert property (@(posedge clk) disable iff (!rst_n)
            !ovl_active);
      end else begin : g_retail
         // R5: overlay enabled when reset releases
         a_r5_retail_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> ovl_active);
      end
   endgenerate

endmodule

bind boot_overlay_decoder bovl_checker #(
   .DEV_BUILD(DEV_BUILD)
) u_bovl_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_req     (rd_req),
   .rd_size    (rd_size),
   .ovl_disable(ovl_disable),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .ovl_active (ovl_active)
);

// File: tb/boot_overlay_decoder_bench.sv
module boot_overlay_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_req = 1'b0;
   logic [31:0] rd_addr = 32'd0;
   logic [1:0]  rd_size = 2'd0;
   logic        dis_r = 1'b0;
   logic        dis_d = 1'b0;

   logic        v_r, e_r, a_r, v_d, e_d, a_d;
   logic [31:0] d_r, d_d;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit ovl_model = 1;

   always #4 clk = ~clk;

   boot_overlay_decoder #(.DEV_BUILD(1'b0), .ALIAS_EN(1'b1)) u_boot_overlay_decoder (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
      .ovl_disable(dis_r), .rd_valid(v_r), .rd_data(d_r), .rd_err(e_r), .ovl_active(a_r));

   boot_overlay_decoder #(.DEV_BUILD(1'b1), .ALIAS_EN(1'b0)) u_dev (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
      .ovl_disable(dis_d), .rd_valid(v_d), .rd_data(d_d), .rd_err(e_d), .ovl_active(a_d));

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  sz;
      logic        err_retail;
   } vec_t;

   localparam int NVEC = 15;
   localparam vec_t VEC [NVEC] = '{
      '{32'h0000_0000, 2'd2, 1'b0},
      '{32'h0000_1235, 2'd1, 1'b0},
      '{32'h03FF_FFFE, 2'd2, 1'b1},
      '{32'h0400_0000, 2'd0, 1'b1},
      '{32'hFF00_0000, 2'd2, 1'b0},
      '{32'hFF04_0010, 2'd2, 1'b0},
      '{32'hFFFF_FDFE, 2'd2, 1'b0},
      '{32'hFFFF_FFFE, 2'd2, 1'b0},
      '{32'hF000_0100, 2'd2, 1'b0},
      '{32'hF3FF_FFFF, 2'd0, 1'b0},
      '{32'hF400_0000, 2'd0, 1'b1},
      '{32'h8000_0000, 2'd1, 1'b1},
      '{32'h07FF_FFFF, 2'd0, 1'b1},
      '{32'hFFFF_FE00, 2'd0, 1'b0},
      '{32'h0000_0010, 2'd3, 1'b0}
   };

   // requirement model of one byte: {unmapped, value}
   function automatic logic [8:0] model_byte(logic [31:0] a, bit dev, bit alias_on, bit ovl);
      logic [31:0] ram = dev ? 32'h0800_0000 : 32'h0400_0000;
      logic [31:0] o;
      if (a < ram) return {1'b0, a[7:0] ^ a[26:19]};                       // R1
      if (!dev && ovl && a >= 32'hFFFF_FE00) begin                          // R3
         o = a - 32'hFFFF_FE00;
         return {1'b0, (~o[7:0]) ^ {o[8], 7'b0}};
      end
      if (a >= 32'hFF00_0000) begin                                         // R2
         o = (a - 32'hFF00_0000) % 32'h0004_0000;
         return {1'b0, o[7:0] ^ o[17:10] ^ 8'h3C};
      end
      if (alias_on && a >= 32'hF000_0000 && (a - 32'hF000_0000) < ram) begin // R8
         o = a - 32'hF000_0000;
         return {1'b0, o[7:0] ^ o[26:19]};
      end
      return 9'h100;                                                        // R6
   endfunction

   function automatic logic [32:0] model_read(logic [31:0] a, logic [1:0] sz,
                                              bit dev, bit alias_on, bit ovl);
      logic [31:0] d = 32'd0;
      logic e = 1'b0;
      int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;                      // R7
      for (int k = 0; k < n; k++) begin
         logic [8:0] mb = model_byte(a + 32'(k), dev, alias_on, ovl);        // R9
         d[8*k +: 8] = mb[7:0];
         e = e | mb[8];
      end
      return {e, d};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_read(logic [31:0] a, logic [1:0] sz, bit with_dis);
      @(negedge clk);
      rd_req = 1'b1; rd_addr = a; rd_size = sz; dis_r = with_dis;
      @(negedge clk);
      rd_req = 1'b0; dis_r = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [32:0] m;
      // R10/R5: reset state
      repeat (3) @(negedge clk);
      check("R10 reset valid", {31'd0, v_r}, 32'd0);
      check("R10 reset data", d_r, 32'd0);
      check("R10 reset err", {31'd0, e_r}, 32'd0);
      check("R5 retail overlay at reset", {31'd0, a_r}, 32'd1);
      check("R5 dev overlay at reset", {31'd0, a_d}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 retail overlay after reset", {31'd0, a_r}, 32'd1);

      // vector table: R1 R2 R3 R6 R7 R8 R9
      for (int i = 0; i < NVEC; i++) begin
         do_read(VEC[i].addr, VEC[i].sz, 1'b0);
         check($sformatf("R10 valid retail vec%0d", i), {31'd0, v_r}, 32'd1);
         m = model_read(VEC[i].addr, VEC[i].sz, 0, 1, 1);
         check($sformatf("R1-map retail data vec%0d", i), d_r, m[31:0]);
         check($sformatf("R6 retail err vec%0d", i), {31'd0, e_r}, {31'd0, VEC[i].err_retail});
         m = model_read(VEC[i].addr, VEC[i].sz, 1, 0, 0);
         check($sformatf("R8 dev data vec%0d", i), d_d, m[31:0]);
         check($sformatf("R6 dev err vec%0d", i), {31'd0, e_d}, {31'd0, m[32]});
      end

      // R10: no request, no valid
      @(negedge clk);
      check("R10 idle valid", {31'd0, v_r}, 32'd0);

      // R3: boot ROM byte at top of space
      do_read(32'hFFFF_FE00, 2'd0, 1'b0);
      check("R3 boot byte", d_r, 32'h0000_00FF);
      check("R2 dev flash at top", d_d, 32'h0000_00C3);

      // R5: disabling the dev copy changes nothing
      @(negedge clk); dis_d = 1'b1; @(negedge clk); dis_d = 1'b0;
      check("R5 dev overlay stays off", {31'd0, a_d}, 32'd0);

      // R11: read together with disable sees the overlay
      do_read(32'hFFFF_FE00, 2'd0, 1'b1);
      check("R11 same-cycle read", d_r, 32'h0000_00FF);
      check("R4 overlay cleared", {31'd0, a_r}, 32'd0);

      // R4: top bytes now from flash mirror, and it stays off
      do_read(32'hFFFF_FFFE, 2'd2, 1'b0);
      m = model_read(32'hFFFF_FFFE, 2'd2, 0, 1, 0);
      check("R4 flash after disable", d_r, m[31:0]);
      repeat (5) @(negedge clk);
      check("R4 still off", {31'd0, a_r}, 32'd0);
      do_read(32'hFFFF_FE00, 2'd1, 1'b0);
      m = model_read(32'hFFFF_FE00, 2'd1, 0, 1, 0);
      check("R4 flash halfword", d_r, m[31:0]);

      // R5: reset brings the overlay back
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R10 valid cleared by reset", {31'd0, v_r}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 overlay restored", {31'd0, a_r}, 32'd1);
      do_read(32'hFFFF_FFFF, 2'd0, 1'b0);
      check("R3 last boot byte", d_r, 32'h0000_0080);

      finish_run();
   end

endmodule